// File: doc/BRIEF.md
# Interrupt Cause, Mask and Hold-Off Controller

This block collects interrupt causes for a network interface and drives one level-sensitive interrupt line. Event pulses from the receive and transmit engines, together with software writes, set bits in a cause register. A separate mask register selects which causes may reach the line. Software acknowledges causes either by reading the cause register, which returns the value and empties it, or by writing a clear pattern.

The line only rises when a cause becomes newly active, meaning pending and unmasked where it was not before. After each rise that starts a hold-off window, further rises are suppressed for a programmed number of 256 ns units. The unit is a parameterised number of clock cycles. When the window ends, the line rises again if any active cause is still outstanding. The controller sits behind a simple register port with one write and one read per cycle. Reads return data combinationally in the cycle of the request.

Top module: `irq_throttle_ctrl`

## Requirements
- R1: After reset the cause and mask registers read 0, the hold-off register reads 250, the line is low and no hold-off window runs.
- R2: Event bits and writes with select 2 (cause-set) OR their bits into the cause register. A bit that is already set stays set.
- R3: A write with select 3 (mask-set) ORs into the mask, and a write with select 4 (mask-clear) clears the written mask bits. A mask-clear write never lowers the line by itself.
- R4: A read with select 0 returns the cause register as it was before the cycle and leaves it empty. The line drops unless a cause set in that same cycle is unmasked.
- R5: A write with select 0 (cause-clear) clears the written cause bits. The line drops at that point if no unmasked cause remains pending.
- R6: The line rises one cycle after a cause bit becomes both pending and unmasked, provided the line is low and no hold-off window is running. Pending bits that are masked never raise it.
- R7: A mask-set write that unmasks an already pending cause counts as a new cause under R6.
- R8: When the line rises with the hold-off value nonzero, a window of value × UNIT_CYCLES cycles starts. While the window runs, new causes do not raise the line.
- R9: In the last cycle of a window, the line rises if any unmasked cause is pending and the line is low. A rise made this way starts no new window.
- R10: With a hold-off value of 0, no window starts and the line may rise again in the cycle after it drops.
- R11: Within one cycle the order is read-clear, then cause-clear, then cause-set. A bit both cleared and set in the same cycle ends up set, and it counts as new.
- R12: A write with select 1 loads the low THR_W bits of the hold-off register, and a read with select 1 returns it. A write made while a window runs leaves that window's length unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | CAUSE_W | Cause pulses from the event sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Write select: 0 cause-clear, 1 hold-off, 2 cause-set, 3 mask-set, 4 mask-clear |
| wr_data_i | input | CAUSE_W | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 3 | Read select: 0 cause (clears it), 1 hold-off, 3 mask, others read 0 |
| rd_data_o | output | CAUSE_W | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Level interrupt line |

## Verification
A fault in the cause or mask state shows up at the ports in one of two ways. The next read returns the wrong value, or the line rises or stays low one cycle after a stimulus that should have done the opposite. A fault in the hold-off counter shows up as a rise that comes early or late by at least one cycle at the end of the window. That is why the line is compared against the reference in every cycle, so an error is seen within the cycle it first becomes visible. Window lengths are tried for a short value, a value changed in the middle of a window, zero, and the reset value.

// File: rtl/irq_thr_pkg.sv
package irq_thr_pkg;

    typedef enum logic [2:0] {
        SEL_CAUSE    = 3'd0,
        SEL_HOLDOFF  = 3'd1,
        SEL_CSET     = 3'd2,
        SEL_MSET     = 3'd3,
        SEL_MCLR     = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/irq_cause_mask.sv
module irq_cause_mask #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits_i,
    input  logic [W-1:0] clr_bits_i,
    input  logic         rd_clr_i,
    input  logic [W-1:0] mset_bits_i,
    input  logic [W-1:0] mclr_bits_i,
    output logic [W-1:0] cause_o,
    output logic [W-1:0] mask_o,
    output logic         active_o,
    output logic         fresh_o
);

    typedef struct packed {
        logic [W-1:0] cause;
        logic [W-1:0] mask;
    } cm_state_t;

    cm_state_t st_d, st_q;
    logic [W-1:0] base_c;
    logic [W-1:0] act_before_c;
    logic [W-1:0] act_after_c;

    always_comb begin
        st_d = st_q;
        // ordering: read-clear, then clear pattern, then sets
        base_c = rd_clr_i ? '0 : st_q.cause;
        base_c = base_c & ~clr_bits_i;
        st_d.cause = base_c | set_bits_i;
        st_d.mask  = (st_q.mask | mset_bits_i) & ~mclr_bits_i;
        act_before_c = base_c & st_q.mask;
        act_after_c  = st_d.cause & st_d.mask;
        active_o = |act_after_c;
        fresh_o  = |(act_after_c & ~act_before_c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;

endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer #(
    parameter int THR_W       = 16,
    parameter int UNIT_CYCLES = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [THR_W-1:0] interval_i,
    output logic             busy_o,
    output logic             expire_o
);

    localparam int PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);
    localparam logic [THR_W-1:0] IVL_ONE  = THR_W'(1);

    typedef struct packed {
        logic             running;
        logic [PRE_W-1:0] pre;
        logic [THR_W-1:0] ivl;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = st_q.running && (st_q.pre == '0) && (st_q.ivl == IVL_ONE);
        if (st_q.running) begin
            if (st_q.pre == '0) begin
                st_d.pre = PRE_LAST;
                if (st_q.ivl == IVL_ONE) begin
                    st_d.running = 1'b0;
                end else begin
                    st_d.ivl = st_q.ivl - IVL_ONE;
                end
            end else begin
                st_d.pre = st_q.pre - PRE_W'(1);
            end
        end
        if (load_i) begin
            st_d.running = 1'b1;
            st_d.pre     = PRE_LAST;
            st_d.ivl     = interval_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.running;

endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fresh_i,
    input  logic active_i,
    input  logic drop_req_i,
    input  logic hold_i,
    input  logic expire_i,
    input  logic thr_nonzero_i,
    output logic irq_o,
    output logic start_o
);

    typedef struct packed {
        logic irq;
    } line_state_t;

    line_state_t st_d, st_q;
    logic raise_c;
    logic drop_c;

    always_comb begin
        st_d    = st_q;
        raise_c = !st_q.irq && ((fresh_i && !hold_i) || (expire_i && active_i));
        drop_c  = st_q.irq && drop_req_i && !active_i;
        if (raise_c) begin
            st_d.irq = 1'b1;
        end else if (drop_c) begin
            st_d.irq = 1'b0;
        end
        start_o = raise_c && !hold_i && thr_nonzero_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

endmodule

// File: rtl/irq_throttle_ctrl.sv
module irq_throttle_ctrl
    import irq_thr_pkg::*;
#(
    parameter int CAUSE_W     = 32,
    parameter int THR_W       = 16,
    parameter int UNIT_CYCLES = 26,
    parameter int THR_RESET   = 250
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] evt_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [CAUSE_W-1:0] wr_data_i,
    input  logic               rd_en_i,
    input  logic [2:0]         rd_sel_i,
    output logic [CAUSE_W-1:0] rd_data_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [THR_W-1:0] thr;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CAUSE_W-1:0] set_bits, clr_bits, mset_bits, mclr_bits;
    logic [CAUSE_W-1:0] cause_val, mask_val;
    logic               rd_clr;
    logic               cm_active, cm_fresh;
    logic               tmr_busy, tmr_expire, tmr_start;
    logic [THR_W-1:0]   thr_val;

    always_comb begin
        set_bits  = evt_i;
        clr_bits  = '0;
        mset_bits = '0;
        mclr_bits = '0;
        st_d      = st_q;
        if (wr_en_i) begin
            case (reg_sel_e'(wr_sel_i))
                SEL_CAUSE:   clr_bits  = wr_data_i;
                SEL_HOLDOFF: st_d.thr  = wr_data_i[THR_W-1:0];
                SEL_CSET:    set_bits  = evt_i | wr_data_i;
                SEL_MSET:    mset_bits = wr_data_i;
                SEL_MCLR:    mclr_bits = wr_data_i;
                default:     ;
            endcase
        end
        rd_clr    = rd_en_i && (rd_sel_i == SEL_CAUSE);
        rd_data_o = '0;
        if (rd_en_i) begin
            case (reg_sel_e'(rd_sel_i))
                SEL_CAUSE:   rd_data_o = cause_val;
                SEL_HOLDOFF: rd_data_o = CAUSE_W'(st_q.thr);
                SEL_MSET:    rd_data_o = mask_val;
                default:     rd_data_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.thr <= THR_W'(THR_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_val = st_q.thr;

    irq_cause_mask #(.W(CAUSE_W)) u_cm (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits_i (set_bits),
        .clr_bits_i (clr_bits),
        .rd_clr_i   (rd_clr),
        .mset_bits_i(mset_bits),
        .mclr_bits_i(mclr_bits),
        .cause_o    (cause_val),
        .mask_o     (mask_val),
        .active_o   (cm_active),
        .fresh_o    (cm_fresh)
    );

    irq_hold_timer #(.THR_W(THR_W), .UNIT_CYCLES(UNIT_CYCLES)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_start),
        .interval_i(thr_val),
        .busy_o    (tmr_busy),
        .expire_o  (tmr_expire)
    );

    irq_line_gate u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .fresh_i      (cm_fresh),
        .active_i     (cm_active),
        .drop_req_i   (rd_clr || (clr_bits != '0)),
        .hold_i       (tmr_busy),
        .expire_i     (tmr_expire),
        .thr_nonzero_i(thr_val != '0),
        .irq_o        (irq_o),
        .start_o      (tmr_start)
    );

endmodule

// File: rtl/irq_throttle_chk.sv
module irq_throttle_chk #(
    parameter int CAUSE_W = 32,
    parameter int THR_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               irq_o,
    input logic [CAUSE_W-1:0] evt_i,
    input logic               wr_en_i,
    input logic [2:0]         wr_sel_i,
    input logic               rd_en_i,
    input logic [2:0]         rd_sel_i,
    input logic               tmr_busy,
    input logic               tmr_expire,
    input logic               cm_fresh,
    input logic [THR_W-1:0]   thr_val
);

    // R4
    read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_sel_i == 3'd0 && evt_i == '0 && !(wr_en_i && wr_sel_i == 3'd2))
        |=> !irq_o);

    // R8
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && tmr_busy && !tmr_expire) |=> !irq_o);

    // R3
    mask_clr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && wr_en_i && wr_sel_i == 3'd4 && !(rd_en_i && rd_sel_i == 3'd0))
        |=> irq_o);

    // R8
    window_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !tmr_busy && cm_fresh && thr_val != '0) |=> (irq_o && tmr_busy));

    // R9
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $past(tmr_expire)) |-> !tmr_busy);

endmodule

bind irq_throttle_ctrl irq_throttle_chk #(.CAUSE_W(CAUSE_W), .THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .evt_i     (evt_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .tmr_busy  (tmr_busy),
    .tmr_expire(tmr_expire),
    .cm_fresh  (cm_fresh),
    .thr_val   (thr_val)
);

// File: tb/irq_throttle_ctrl_test.sv
module irq_throttle_ctrl_test;

    localparam int U = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_sel_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [2:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask = '0;
    int          m_thr = 250;
    bit          m_irq = 0;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    irq_throttle_ctrl #(.CAUSE_W(32), .THR_W(16), .UNIT_CYCLES(U), .THR_RESET(250)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_sel_i(rd_sel_i),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic [31:0] evt, input bit we, input logic [2:0] ws,
                       input logic [31:0] wd, input bit re, input logic [2:0] rs,
                       input string tag);
        logic [31:0] setb, clrb, msetb, mclrb, base, cdn, mdn, actb, act, rexp;
        bit fresh, dropreq, rise;
        @(negedge clk);
        chk({tag, " line"}, {31'd0, irq_o}, {31'd0, m_irq});
        evt_i = evt; wr_en_i = we; wr_sel_i = ws; wr_data_i = wd;
        rd_en_i = re; rd_sel_i = rs;
        #1;
        if (re) begin
            rexp = (rs == 3'd0) ? m_cause : (rs == 3'd1) ? 32'(m_thr) :
                   (rs == 3'd3) ? m_mask : 32'd0;
            chk({tag, " read"}, rd_data_o, rexp);
        end
        setb  = evt | ((we && ws == 3'd2) ? wd : 32'd0);
        clrb  = (we && ws == 3'd0) ? wd : 32'd0;
        msetb = (we && ws == 3'd3) ? wd : 32'd0;
        mclrb = (we && ws == 3'd4) ? wd : 32'd0;
        base  = (re && rs == 3'd0) ? 32'd0 : m_cause;
        base  = base & ~clrb;
        cdn   = base | setb;
        mdn   = (m_mask | msetb) & ~mclrb;
        actb  = base & m_mask;
        act   = cdn & mdn;
        fresh = (act & ~actb) != 0;
        dropreq = (re && rs == 3'd0) || (clrb != 0);
        rise = 0;
        if (m_irq) begin
            if (dropreq && act == 0) m_irq = 0;
        end else if ((fresh && m_cnt == 0) || (m_cnt == 1 && act != 0)) begin
            rise = 1;
            m_irq = 1;
        end
        if (rise && m_cnt == 0 && m_thr != 0) m_cnt = m_thr * U;
        else if (m_cnt > 0) m_cnt--;
        m_cause = cdn;
        m_mask = mdn;
        if (we && ws == 3'd1) m_thr = int'(wd[15:0]);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [2:0] s, input logic [31:0] d, input string tag);
        cyc(0, 1, s, d, 0, 0, tag);
    endtask
    task automatic rd(input logic [2:0] s, input string tag);
        cyc(0, 0, 0, 0, 1, s, tag);
    endtask
    task automatic ev(input logic [31:0] b, input string tag);
        cyc(b, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset values
        @(negedge clk);
        chk("R1 line", {31'd0, irq_o}, 32'd0);
        rd(0, "R1"); rd(3, "R1"); rd(1, "R1");
        // R12 hold-off register, then zero for immediate response
        wr(1, 32'h0, "R12"); rd(1, "R12");
        // R3 mask set
        wr(3, 32'h1, "R3"); rd(3, "R3");
        // R2 R6 event raises line
        ev(32'h1, "R2"); idle(2, "R6");
        // masked cause-set does nothing, then read clears (R4)
        wr(2, 32'h10, "R2"); idle(1, "R6");
        rd(0, "R4"); idle(2, "R4");
        // R7 unmask a pending cause
        wr(2, 32'h10, "R7"); idle(1, "R7");
        wr(3, 32'h10, "R7"); idle(1, "R7");
        // R3 mask-clear does not drop line
        wr(4, 32'h11, "R3"); idle(2, "R3"); rd(3, "R3");
        wr(3, 32'h10, "R7");
        // R5 cause-clear drops line
        wr(0, 32'h10, "R5"); idle(2, "R5"); rd(0, "R5");
        // R11 clear and set of the same bit in one cycle
        cyc(32'h10, 1, 0, 32'h10, 0, 0, "R11"); idle(2, "R11");
        cyc(32'h10, 0, 0, 0, 1, 0, "R11"); idle(2, "R11");
        rd(0, "R11"); idle(1, "R11");
        // R8 R9 hold-off window of 3 units
        wr(1, 32'd3, "R12");
        ev(32'h10, "R8"); idle(1, "R8");
        rd(0, "R8");
        ev(32'h10, "R8");
        wr(1, 32'd7, "R12");
        idle(20, "R9");
        rd(0, "R9");
        ev(32'h10, "R9"); idle(2, "R9");
        rd(0, "R8"); idle(40, "R8");
        // R10 zero hold-off: immediate re-rise
        wr(1, 32'd0, "R10");
        ev(32'h10, "R10"); rd(0, "R10");
        ev(32'h10, "R10"); idle(1, "R10");
        rd(0, "R10"); idle(1, "R10");
        // R8 reset-value window length
        wr(1, 32'd250, "R8");
        ev(32'h10, "R8"); rd(0, "R8"); ev(32'h10, "R8");
        idle(1300, "R9");
        rd(0, "R1"); idle(3, "R1");
        finish_run();
    end

endmodule